// File: doc/BRIEF.md
# Shared-Bus Tenure Controller

This block manages bus ownership for one master on a bus it shares with other masters under an external arbiter. It watches the grant line and the shared transfer-start line. It raises a request when internal logic wants the bus, and it opens the shared bus drivers only once it actually launches a cycle. When its tenure is over, it announces the release on an open-drain termination line.

While another master owns the bus, the controller can be pulled into a one-clock snoop state. A grant with no pending work gives implicit ownership, in which nothing is driven. Launching a cycle moves the block to explicit ownership, which lasts until the grant goes away or a reset request arrives. Release always runs a two-clock handshake: the termination line is pulled low for one clock, driven high for one clock, and then floated.

States: ST_ALT (another master owns the bus), ST_SNOOP, ST_IMPL (implicit ownership), ST_LAUNCH (first clock of a cycle), ST_XFER (cycle in flight), ST_HOLD (explicit ownership, idle), ST_END_ON (termination pulled low) and ST_END_OFF (termination driven high). Transitions:
- ST_ALT to ST_SNOOP on a qualified snoop.
- ST_ALT to ST_IMPL on a grant with the start line quiet.
- ST_IMPL to ST_LAUNCH when a request is pending, and ST_IMPL back to ST_ALT when the grant is lost.
- ST_LAUNCH to ST_XFER.
- ST_XFER, on cycle done, to ST_END_ON, ST_LAUNCH or ST_HOLD.
- ST_HOLD to ST_LAUNCH or ST_END_ON.
- ST_END_ON to ST_END_OFF, then ST_END_OFF to ST_ALT.
- ST_SNOOP to ST_ALT.

Top module: `bus_tenure_ctrl`

## Requirements
- R1: After synchronous reset (rst_n low at a rising edge), every output is 0: no request, bus and termination drivers off, and no start or snoop flag.
- R2: In ST_ALT, sampling xfer_start_i=1, snoop_req_i=1 and xfer_kind_i=0 sets snoop_busy_o for exactly one clock, with the bus undriven, and then returns to ST_ALT. With xfer_kind_i=1 the same inputs have no effect.
- R3: A req_pulse_i sets a pending request. While the block does not own the bus (ST_ALT or ST_SNOOP), bus_req_o shows that request from the next clock. A req_cancel_i clears it on the next clock without any use of the bus.
- R4: If grant_i and xfer_start_i are both sampled high in ST_ALT, another master is taken to have started a cycle. The block stays in ST_ALT, bus_oe_o stays 0 and the request stays pending.
- R5: A grant with the start line quiet enters ST_IMPL, where nothing is driven. Losing the grant there returns to ST_ALT with no termination pulse.
- R6: In ST_IMPL with a request pending, the next clock is ST_LAUNCH. cycle_start_o is 1 for that one clock, bus_oe_o=1 and term_oe_o=1 with term_low_o=0.
- R7: After cycle_done_i, with the grant still held and nothing pending, the block stays in ST_HOLD and keeps driving the bus with no new start.
- R8: If the grant drops during a cycle, the bus stays driven until cycle_done_i and only then does end tenure begin.
- R9: End tenure gives one clock of term_oe_o=1 with term_low_o=1, then one clock of term_oe_o=1 with term_low_o=0, then term_oe_o=0. bus_oe_o is 0 in both end-tenure clocks.
- R10: sys_reset_req_i sampled high in ST_HOLD, or at cycle_done_i, enters end tenure even while the grant is held.
- R11: A request pending at cycle_done_i, with the grant held, launches the next cycle directly (ST_LAUNCH).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| grant_i | input | 1 | Grant from the external arbiter |
| xfer_start_i | input | 1 | Shared transfer-start line as seen on the bus |
| snoop_req_i | input | 1 | Snoop qualifier from the bus |
| xfer_kind_i | input | 1 | Transfer-type bit; 0 allows a snoop |
| sys_reset_req_i | input | 1 | Reset request that forces a release |
| req_pulse_i | input | 1 | Internal request for the bus |
| req_cancel_i | input | 1 | Withdraws a pending request |
| cycle_done_i | input | 1 | Current master cycle has finished |
| bus_req_o | output | 1 | Bus request to the arbiter |
| term_low_o | output | 1 | Pull the open-drain termination line low |
| term_oe_o | output | 1 | Drive enable for the termination line |
| bus_oe_o | output | 1 | Drive enable for the shared bus |
| cycle_start_o | output | 1 | One-clock strobe at the start of a master cycle |
| snoop_busy_o | output | 1 | Snoop in progress |

## Verification
The block has no parameters, so the bench builds it as it is. Because the block is this small, every state and every transition listed above can be reached with short directed sequences. These cover the grant-versus-start race, a request withdrawn before use, a grant lost in the middle of a cycle, a reset request while idle-owning, and back-to-back launches. The bench models the termination line's pull-up to check the low, high and floating phases of the release handshake.

// File: rtl/tenure_pkg.sv
package tenure_pkg;
    localparam int STATE_W = 3;

    typedef enum logic [STATE_W-1:0] {
        ST_ALT     = 3'd0,
        ST_SNOOP   = 3'd1,
        ST_IMPL    = 3'd2,
        ST_LAUNCH  = 3'd3,
        ST_XFER    = 3'd4,
        ST_HOLD    = 3'd5,
        ST_END_ON  = 3'd6,
        ST_END_OFF = 3'd7
    } tenure_state_e;

    typedef struct packed {
        logic bus_req;
        logic bus_oe;
        logic term_oe;
        logic term_low;
        logic cycle_start;
        logic snoop_busy;
    } tenure_out_t;
endpackage

// File: rtl/tenure_req_tracker.sv
module tenure_req_tracker (
    input  logic clk,
    input  logic rst_n,
    input  logic req_pulse_i,
    input  logic req_cancel_i,
    input  logic launch_i,
    output logic pending_o
);
    logic pending_q;
    logic pending_d;

    // A launch consumes the request; a fresh pulse in the same clock re-arms it.
    always_comb begin
        pending_d = pending_q & ~launch_i;
        if (req_pulse_i)
            pending_d = 1'b1;
        if (req_cancel_i)
            pending_d = 1'b0;
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            pending_q <= 1'b0;
        else
            pending_q <= pending_d;
    end

    assign pending_o = pending_q;
endmodule

// File: rtl/tenure_fsm.sv
module tenure_fsm
    import tenure_pkg::*;
(
    input  logic          clk,
    input  logic          rst_n,
    input  logic          grant_i,
    input  logic          xfer_start_i,
    input  logic          snoop_req_i,
    input  logic          xfer_kind_i,
    input  logic          sys_reset_req_i,
    input  logic          cycle_done_i,
    input  logic          pending_i,
    output tenure_state_e state_o,
    output logic          launch_o
);
    tenure_state_e state_q;
    tenure_state_e state_d;
    logic          snoop_hit;
    logic          must_release;

    assign snoop_hit    = xfer_start_i & snoop_req_i & ~xfer_kind_i;
    assign must_release = ~grant_i | sys_reset_req_i;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_ALT: begin
                if (snoop_hit)
                    state_d = ST_SNOOP;
                else if (grant_i && !xfer_start_i)
                    state_d = ST_IMPL;
            end
            ST_SNOOP:
                state_d = ST_ALT;
            ST_IMPL: begin
                if (!grant_i)
                    state_d = ST_ALT;
                else if (pending_i && !sys_reset_req_i)
                    state_d = ST_LAUNCH;
            end
            ST_LAUNCH:
                state_d = ST_XFER;
            ST_XFER: begin
                if (cycle_done_i) begin
                    if (must_release)
                        state_d = ST_END_ON;
                    else if (pending_i)
                        state_d = ST_LAUNCH;
                    else
                        state_d = ST_HOLD;
                end
            end
            ST_HOLD: begin
                if (must_release)
                    state_d = ST_END_ON;
                else if (pending_i)
                    state_d = ST_LAUNCH;
            end
            ST_END_ON:
                state_d = ST_END_OFF;
            ST_END_OFF:
                state_d = ST_ALT;
            default:
                state_d = ST_ALT;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            state_q <= ST_ALT;
        else
            state_q <= state_d;
    end

    assign state_o  = state_q;
    assign launch_o = (state_d == ST_LAUNCH);
endmodule

// File: rtl/tenure_out_decode.sv
module tenure_out_decode
    import tenure_pkg::*;
(
    input  tenure_state_e state_i,
    input  logic          pending_i,
    output tenure_out_t   out_o
);
    always_comb begin
        out_o = '0;
        unique case (state_i)
            ST_ALT, ST_SNOOP: begin
                out_o.bus_req    = pending_i;
                out_o.snoop_busy = (state_i == ST_SNOOP);
            end
            ST_IMPL: begin
                out_o = '0;
            end
            ST_LAUNCH: begin
                out_o.bus_oe      = 1'b1;
                out_o.term_oe     = 1'b1;
                out_o.cycle_start = 1'b1;
            end
            ST_XFER, ST_HOLD: begin
                out_o.bus_oe  = 1'b1;
                out_o.term_oe = 1'b1;
            end
            ST_END_ON: begin
                out_o.term_oe  = 1'b1;
                out_o.term_low = 1'b1;
            end
            ST_END_OFF: begin
                out_o.term_oe = 1'b1;
            end
            default: out_o = '0;
        endcase
    end
endmodule

// File: rtl/bus_tenure_ctrl.sv
module bus_tenure_ctrl
    import tenure_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic grant_i,
    input  logic xfer_start_i,
    input  logic snoop_req_i,
    input  logic xfer_kind_i,
    input  logic sys_reset_req_i,
    input  logic req_pulse_i,
    input  logic req_cancel_i,
    input  logic cycle_done_i,
    output logic bus_req_o,
    output logic term_low_o,
    output logic term_oe_o,
    output logic bus_oe_o,
    output logic cycle_start_o,
    output logic snoop_busy_o
);
    tenure_state_e state;
    logic          pending;
    logic          launch;
    tenure_out_t   outs;

    tenure_req_tracker u_req (
        .clk          (clk),
        .rst_n        (rst_n),
        .req_pulse_i  (req_pulse_i),
        .req_cancel_i (req_cancel_i),
        .launch_i     (launch),
        .pending_o    (pending)
    );

    tenure_fsm u_fsm (
        .clk             (clk),
        .rst_n           (rst_n),
        .grant_i         (grant_i),
        .xfer_start_i    (xfer_start_i),
        .snoop_req_i     (snoop_req_i),
        .xfer_kind_i     (xfer_kind_i),
        .sys_reset_req_i (sys_reset_req_i),
        .cycle_done_i    (cycle_done_i),
        .pending_i       (pending),
        .state_o         (state),
        .launch_o        (launch)
    );

    tenure_out_decode u_dec (
        .state_i   (state),
        .pending_i (pending),
        .out_o     (outs)
    );

    assign bus_req_o     = outs.bus_req;
    assign bus_oe_o      = outs.bus_oe;
    assign term_oe_o     = outs.term_oe;
    assign term_low_o    = outs.term_low;
    assign cycle_start_o = outs.cycle_start;
    assign snoop_busy_o  = outs.snoop_busy;
endmodule

// File: rtl/bus_tenure_ctrl_chk.sv
module bus_tenure_ctrl_chk (
    input logic clk,
    input logic rst_n,
    input logic grant_i,
    input logic bus_req_o,
    input logic term_low_o,
    input logic term_oe_o,
    input logic bus_oe_o,
    input logic cycle_start_o,
    input logic snoop_busy_o
);
    AST_SNOOP_ONE_CLOCK: assert property (@(posedge clk) disable iff (!rst_n)
        snoop_busy_o |=> !snoop_busy_o); // R2
    AST_SNOOP_UNDRIVEN: assert property (@(posedge clk) disable iff (!rst_n)
        snoop_busy_o |-> !bus_oe_o); // R2
    AST_REQ_ONLY_UNOWNED: assert property (@(posedge clk) disable iff (!rst_n)
        bus_req_o |-> (!bus_oe_o && !term_oe_o)); // R3
    AST_DRIVE_NEEDS_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(bus_oe_o) |-> $past(grant_i)); // R5
    AST_START_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        cycle_start_o |=> !cycle_start_o); // R6
    AST_START_DRIVES: assert property (@(posedge clk) disable iff (!rst_n)
        cycle_start_o |-> (bus_oe_o && term_oe_o && !term_low_o)); // R6
    AST_TERM_LOW_ENABLED: assert property (@(posedge clk) disable iff (!rst_n)
        term_low_o |-> (term_oe_o && !bus_oe_o)); // R9
    AST_TERM_LOW_THEN_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        term_low_o |=> (term_oe_o && !term_low_o && !bus_oe_o)); // R9
    AST_TERM_THEN_FLOAT: assert property (@(posedge clk) disable iff (!rst_n)
        (term_oe_o && !term_low_o && $past(term_low_o)) |=> (!term_oe_o && !bus_oe_o)); // R9
endmodule

bind bus_tenure_ctrl bus_tenure_ctrl_chk i_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .grant_i       (grant_i),
    .bus_req_o     (bus_req_o),
    .term_low_o    (term_low_o),
    .term_oe_o     (term_oe_o),
    .bus_oe_o      (bus_oe_o),
    .cycle_start_o (cycle_start_o),
    .snoop_busy_o  (snoop_busy_o)
);

// File: tb/test_bus_tenure_ctrl.sv
module test_bus_tenure_ctrl;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic grant = 1'b0, xstart = 1'b0, snp = 1'b0, xkind = 1'b0;
    logic sreset = 1'b0, rpulse = 1'b0, rcancel = 1'b0, done = 1'b0;
    logic br, tlow, toe, boe, cstart, sbusy;
    int total = 0;
    int bad = 0;

    always #5 clk = ~clk;

    bus_tenure_ctrl i_bus_tenure_ctrl (
        .clk(clk), .rst_n(rst_n), .grant_i(grant), .xfer_start_i(xstart),
        .snoop_req_i(snp), .xfer_kind_i(xkind), .sys_reset_req_i(sreset),
        .req_pulse_i(rpulse), .req_cancel_i(rcancel), .cycle_done_i(done),
        .bus_req_o(br), .term_low_o(tlow), .term_oe_o(toe), .bus_oe_o(boe),
        .cycle_start_o(cstart), .snoop_busy_o(sbusy)
    );

    // external pull-up on the termination line
    wire term_line = (toe && tlow) ? 1'b0 : 1'b1;

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    // expected order: {br, boe, toe, tlow, cstart, sbusy}
    task automatic expect_out(input string req, input logic [5:0] exp);
        logic [5:0] act;
        act = {br, boe, toe, tlow, cstart, sbusy};
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: outputs actual=%b expected=%b", req, act, exp);
        end
    endtask

    task automatic expect_line(input string req, input logic exp);
        total++;
        if (term_line !== exp) begin
            bad++;
            $display("FAIL %s: term line actual=%b expected=%b", req, term_line, exp);
        end
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        step(); step();
        expect_out("R1", 6'b000000);
        rst_n = 1'b1;
        step();
        expect_out("R1", 6'b000000);
    endtask

    task automatic t_snoop();
        xstart = 1; snp = 1; xkind = 0;
        step();
        expect_out("R2", 6'b000001);
        xstart = 0; snp = 0;
        step();
        expect_out("R2", 6'b000000);
        xstart = 1; snp = 1; xkind = 1;
        step();
        expect_out("R2", 6'b000000);
        xstart = 0; snp = 0; xkind = 0;
        step();
    endtask

    task automatic t_cancel_and_implicit();
        rpulse = 1; step(); rpulse = 0;
        expect_out("R3", 6'b100000);
        step();
        expect_out("R3", 6'b100000);
        rcancel = 1; step(); rcancel = 0;
        expect_out("R3", 6'b000000);
        grant = 1; step();
        expect_out("R5", 6'b000000);
        step();
        expect_out("R5", 6'b000000);
        expect_line("R5", 1'b1);
        grant = 0; step();
        expect_out("R5", 6'b000000);
        step();
        expect_out("R5", 6'b000000);
    endtask

    task automatic t_race_and_release();
        rpulse = 1; step(); rpulse = 0;
        grant = 1; xstart = 1; step();
        expect_out("R4", 6'b100000);
        xstart = 0; step();
        expect_out("R5", 6'b000000);
        step();
        expect_out("R6", 6'b011010);
        expect_line("R6", 1'b1);
        step();
        expect_out("R6", 6'b011000);
        done = 1; step(); done = 0;
        expect_out("R7", 6'b011000);
        step();
        expect_out("R7", 6'b011000);
        grant = 0; step();
        expect_out("R9", 6'b001100);
        expect_line("R9", 1'b0);
        step();
        expect_out("R9", 6'b001000);
        expect_line("R9", 1'b1);
        step();
        expect_out("R9", 6'b000000);
    endtask

    task automatic t_grant_loss_mid_cycle();
        rpulse = 1; grant = 1; step(); rpulse = 0;
        expect_out("R8", 6'b000000);
        step();
        expect_out("R8", 6'b011010);
        grant = 0; step();
        expect_out("R8", 6'b011000);
        step();
        expect_out("R8", 6'b011000);
        done = 1; step(); done = 0;
        expect_out("R8", 6'b001100);
        step();
        expect_out("R9", 6'b001000);
        step();
        expect_out("R9", 6'b000000);
    endtask

    task automatic t_reset_request();
        rpulse = 1; grant = 1; step(); rpulse = 0;
        step();
        expect_out("R10", 6'b011010);
        done = 1; step(); done = 1; step(); done = 0;
        expect_out("R10", 6'b011000);
        sreset = 1; step(); sreset = 0;
        expect_out("R10", 6'b001100);
        grant = 0; step();
        expect_out("R10", 6'b001000);
        step();
        expect_out("R10", 6'b000000);
    endtask

    task automatic t_back_to_back();
        rpulse = 1; grant = 1; step(); rpulse = 0;
        step();
        expect_out("R11", 6'b011010);
        rpulse = 1; step(); rpulse = 0;
        expect_out("R11", 6'b011000);
        done = 1; step(); done = 0;
        expect_out("R11", 6'b011010);
        step();
        expect_out("R11", 6'b011000);
        done = 1; grant = 0; step(); done = 0;
        expect_out("R11", 6'b001100);
        step(); step();
        expect_out("R11", 6'b000000);
    endtask

    initial begin
        repeat (5000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        t_reset();
        t_snoop();
        t_cancel_and_implicit();
        t_race_and_release();
        t_grant_loss_mid_cycle();
        t_reset_request();
        t_back_to_back();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule